// File: doc/BRIEF.md
# Video Prefetch Fetch Controller

This block keeps a video FIFO stocked with image data ahead of the raster sequencer that drains it. Software writes the image start word address. The pixel width, line count and line pitch are sampled with that write. The block then raises its busy and prefetch status flags and walks the image region. It issues one word read at a time on a request/acknowledge memory port and pushes each returned word into the FIFO. It asks for a word only while the FIFO has a free slot.

The block keeps its own countdown of words per line and lines per image. A line holds the pixel width rounded up to whole 16-bit words. When the last word of the last line has been acknowledged, busy drops and the block idles. The prefetch flag marks the window before the raster sequencer reports that it is running. A second start during a fetch, or a start with a zero dimension, is refused and recorded in a sticky error flag.

Top module: `vpf_fetch_ctrl`

## Requirements
- R1: While reset is held, and at the first edge after it, `pf_busy`, `pf_prefetch`, `pf_error`, `mem_req` and `fifo_push` are all 0.
- R2: A start write (`img_wr`=1) accepted in idle with nonzero width and height makes `pf_busy` and `pf_prefetch` both 1 at the next edge.
- R3: The number of words per line is ceil(`img_width_px`/16), and exactly that count times `img_height` words are pushed per image.
- R4: The first word address equals `img_base`. Within a line each next address is the previous one plus 1. Each new line starts at the previous line's start address plus `img_pitch`, modulo 2^AW.
- R5: `mem_req` is asserted only while `fifo_level` < DEPTH, so the FIFO never overflows. Once raised, `mem_req` and `mem_addr` hold steady until `mem_ack` is 1.
- R6: `fifo_push` is 1 in exactly the cycles where `mem_req` and `mem_ack` are both 1, and `fifo_wdata` equals `mem_rdata` in that cycle.
- R7: `pf_busy` is 0 in the cycle after the acknowledge of the final word, and no further request follows.
- R8: `pf_prefetch` stays 1 while busy until `vseq_running` is sampled 1, and is 0 from the next edge on. It also clears when the fetch completes.
- R9: A start write while busy has no effect on the fetch in progress, and it sets `pf_error`.
- R10: A start write with zero width or zero height starts no fetch: busy stays 0, no request is issued, and `pf_error` is set.
- R11: `pf_error` stays 1 through later fetches and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| img_wr | input | 1 | Start write strobe for the image start address |
| img_base | input | AW (24) | Image start word address |
| img_width_px | input | PXW (14) | Image width in pixels |
| img_height | input | HW (12) | Image height in lines |
| img_pitch | input | AW (24) | Word distance between consecutive line starts |
| vseq_running | input | 1 | Raster sequencer reports it has started |
| fifo_level | input | clog2(DEPTH+1) (4) | Words currently held in the video FIFO |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW (24) | Word address of the request |
| mem_ack | input | 1 | Memory accepts the request; data valid this cycle |
| mem_rdata | input | DW (16) | Read data returned with the acknowledge |
| fifo_push | output | 1 | Write one word into the FIFO |
| fifo_wdata | output | DW (16) | Word written into the FIFO |
| pf_busy | output | 1 | Fetch in progress |
| pf_prefetch | output | 1 | Fetch started, raster sequencer not yet running |
| pf_error | output | 1 | Sticky flag for a refused start write |

## Verification
The assertions take for granted that `fifo_level` counts a pushed word from the following cycle and otherwise only falls. They also assume `mem_ack` is never 1 without a request, and `img_wr` is not held across several cycles unless it is meant as repeated writes. The bench keeps to these conditions. Its FIFO model updates its count at the clock edge from `fifo_push` and its own pop, and pops only when the count is nonzero. Its memory model derives the acknowledge from `mem_req` gated by a stall pattern.

// File: rtl/vpf_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the video prefetch fetch controller.
// Assumes: nothing beyond the controller using these encodings.
package vpf_pkg;

    // Fetch sequencer states.
    typedef enum logic [1:0] {
        VPF_IDLE = 2'd0,
        VPF_WAIT = 2'd1,
        VPF_REQ  = 2'd2
    } vpf_state_e;

endpackage

// File: rtl/vpf_geom.sv
`timescale 1ns/1ps
// Module: vpf_geom
// Keeps the fetch-side copy of the image geometry: words left in the
// current line and lines left in the image. Derives words per line by
// rounding the pixel width up to whole 16-pixel words.
// Assumes: load and step never coincide, and width and height are nonzero
// when load is asserted.
module vpf_geom #(
    parameter int PXW = 14,
    parameter int HW  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [PXW-1:0] width_px,
    input  logic [HW-1:0]  height,
    input  logic           step,
    output logic           line_end,
    output logic           last_word
);
    localparam int CW = PXW - 3;

    logic [CW-1:0] wpl_next;
    logic [CW-1:0] wpl_q;
    logic [CW-1:0] col_q;
    logic [HW-1:0] row_q;

    // Words per line: whole words plus one for a partial word.
    always_comb begin
        wpl_next = CW'(width_px >> 4) + CW'(|width_px[3:0]);
    end

    // Count words within the line and lines within the image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpl_q <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (load) begin
            wpl_q <= wpl_next;
            col_q <= wpl_next;
            row_q <= height;
        end else if (step) begin
            if (col_q == CW'(1)) begin
                col_q <= wpl_q;
                row_q <= row_q - HW'(1);
            end else begin
                col_q <= col_q - CW'(1);
            end
        end
    end

    // Flag the final word of a line and of the image.
    always_comb begin
        line_end  = (col_q == CW'(1));
        last_word = line_end && (row_q == HW'(1));
    end

    // R3: a word is never fetched with an exhausted countdown.
    a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col_q != '0) && (row_q != '0));

endmodule

// File: rtl/vpf_addr.sv
`timescale 1ns/1ps
// Module: vpf_addr
// Generates the word address stream: +1 within a line, and line start
// plus pitch at each line end. Pitch is captured together with the base.
// Assumes: load and step never coincide; addresses wrap modulo 2^AW.
module vpf_addr #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pitch,
    input  logic          step,
    input  logic          line_end,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] line_q;
    logic [AW-1:0] pitch_q;

    // Advance the current and line-start addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            line_q  <= '0;
            pitch_q <= '0;
        end else if (load) begin
            addr_q  <= base;
            line_q  <= base;
            pitch_q <= pitch;
        end else if (step) begin
            if (line_end) begin
                addr_q <= line_q + pitch_q;
                line_q <= line_q + pitch_q;
            end else begin
                addr_q <= addr_q + AW'(1);
            end
        end
    end

    // Drive the address output.
    always_comb begin
        addr = addr_q;
    end

    // R4: the line start moves only at a line end.
    a_r4_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !line_end) |=> $stable(line_q));

    // R4: the address moves only on a fetched word or a new image.
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr_q));

endmodule

// File: rtl/vpf_status.sv
`timescale 1ns/1ps
// Module: vpf_status
// Holds the busy, prefetch and sticky error flags.
// Assumes: accept and reject are mutually exclusive, and done only occurs
// while busy.
module vpf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic reject,
    input  logic done,
    input  logic vseq_running,
    output logic busy,
    output logic prefetch,
    output logic err
);
    // Busy spans from an accepted start to the final acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (accept) busy <= 1'b1;
        else if (done)   busy <= 1'b0;
    end

    // Prefetch spans from the start to sequencer running or completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                    prefetch <= 1'b0;
        else if (accept)               prefetch <= 1'b1;
        else if (vseq_running || done) prefetch <= 1'b0;
    end

    // Error latches any refused start until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (reject) err <= 1'b1;
    end

    // R11: the error flag never falls outside reset.
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: prefetch is only ever a sub-window of busy.
    a_r8_pref_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prefetch |-> busy);

endmodule

// File: rtl/vpf_fetch_ctrl.sv
`timescale 1ns/1ps
// Module: vpf_fetch_ctrl (top)
// Fills a video FIFO from memory for one image region per start write.
// Issues single-word requests only when the FIFO has a free slot, and
// pushes each acknowledged word straight into the FIFO.
// Assumes: fifo_level counts a pushed word from the next cycle on and is
// otherwise only lowered by the consumer; mem_ack only while mem_req.
module vpf_fetch_ctrl #(
    parameter int AW    = 24,
    parameter int PXW   = 14,
    parameter int HW    = 12,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            img_wr,
    input  logic [AW-1:0]   img_base,
    input  logic [PXW-1:0]  img_width_px,
    input  logic [HW-1:0]   img_height,
    input  logic [AW-1:0]   img_pitch,
    input  logic            vseq_running,
    input  logic [LVLW-1:0] fifo_level,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            fifo_push,
    output logic [DW-1:0]   fifo_wdata,
    output logic            pf_busy,
    output logic            pf_prefetch,
    output logic            pf_error
);
    import vpf_pkg::*;

    vpf_state_e state_q;
    vpf_state_e state_d;
    logic       dims_ok;
    logic       accept;
    logic       reject;
    logic       room;
    logic       step;
    logic       line_end;
    logic       last_word;
    logic       done;

    // Classify a start write and the fetch events of this cycle.
    always_comb begin
        dims_ok = (img_width_px != '0) && (img_height != '0);
        accept  = img_wr && (state_q == VPF_IDLE) && dims_ok;
        reject  = img_wr && !accept;
        room    = fifo_level < LVLW'(DEPTH);
        step    = (state_q == VPF_REQ) && mem_ack;
        done    = step && last_word;
    end

    // Next-state logic for the request sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            VPF_IDLE: if (accept) state_d = VPF_WAIT;
            VPF_WAIT: if (room)   state_d = VPF_REQ;
            VPF_REQ:  if (mem_ack) state_d = done ? VPF_IDLE : VPF_WAIT;
            default:  state_d = VPF_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VPF_IDLE;
        else        state_q <= state_d;
    end

    // Memory and FIFO side outputs.
    always_comb begin
        mem_req    = (state_q == VPF_REQ);
        fifo_push  = step;
        fifo_wdata = mem_rdata;
    end

    vpf_geom #(.PXW(PXW), .HW(HW)) u_geom (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .width_px  (img_width_px),
        .height    (img_height),
        .step      (step),
        .line_end  (line_end),
        .last_word (last_word)
    );

    vpf_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .base     (img_base),
        .pitch    (img_pitch),
        .step     (step),
        .line_end (line_end),
        .addr     (mem_addr)
    );

    vpf_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .reject       (reject),
        .done         (done),
        .vseq_running (vseq_running),
        .busy         (pf_busy),
        .prefetch     (pf_prefetch),
        .err          (pf_error)
    );

    // R5: never request into a full FIFO.
    a_r5_room: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (fifo_level < LVLW'(DEPTH)));

    // R5: a pending request holds with a stable address.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7: no memory traffic outside a busy window.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_busy |-> !mem_req);

    // R2: busy and prefetch come up together.
    a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_busy) |-> pf_prefetch);

endmodule

// File: tb/vpf_fetch_ctrl_test.sv
`timescale 1ns/1ps
module vpf_fetch_ctrl_test;
    localparam int AW = 24, PXW = 14, HW = 12, DW = 16, DEPTH = 8, LVLW = 4;

    typedef struct packed {
        logic [13:0] wpx;
        logic [11:0] ht;
        logic [23:0] pitch;
        logic [23:0] base;
        logic [1:0]  mode;
        logic [7:0]  vdelay;
    } vec_t;

    // width, height, pitch, base, pop mode, sequencer start delay
    localparam vec_t VECS [5] = '{
        '{14'd16,  12'd1, 24'h000010, 24'h000100, 2'd0, 8'd20},
        '{14'd17,  12'd3, 24'h000020, 24'h002000, 2'd1, 8'd3},
        '{14'd64,  12'd4, 24'h000004, 24'hFFFFF0, 2'd0, 8'd3},
        '{14'd100, 12'd2, 24'h000040, 24'h005000, 2'd2, 8'd3},
        '{14'd1,   12'd5, 24'h000100, 24'hABC000, 2'd1, 8'd5}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            img_wr = 1'b0;
    logic [AW-1:0]   img_base = '0;
    logic [PXW-1:0]  img_width_px = '0;
    logic [HW-1:0]   img_height = '0;
    logic [AW-1:0]   img_pitch = '0;
    logic            vseq_running = 1'b0;
    logic [LVLW-1:0] fifo_level;
    logic            mem_req, mem_ack, fifo_push;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_rdata, fifo_wdata;
    logic            pf_busy, pf_prefetch, pf_error;
    logic            ack_en = 1'b1, pop_en = 1'b0, tb_pop;
    int              checks = 0, fails = 0, ovf = 0;

    assign mem_ack   = mem_req && ack_en;
    assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;
    assign tb_pop    = pop_en && (fifo_level != '0);

    vpf_fetch_ctrl uut (.*);

    // FIFO occupancy model.
    always @(posedge clk) begin
        if (!rst_n) fifo_level <= '0;
        else case ({fifo_push, tb_pop})
            2'b10: if (fifo_level == LVLW'(DEPTH)) ovf <= ovf + 1;
                   else fifo_level <= fifo_level + 1'b1;
            2'b01: fifo_level <= fifo_level - 1'b1;
            default: ;
        endcase
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic run_vec(input vec_t v, input int inject, input bit exp_err);
        int wpl = (int'(v.wpx) + 15) / 16;
        int total = wpl * int'(v.ht);
        int pushes = 0, line = 0, word = 0, bad_addr = 0, bad_data = 0;
        int full_req = 0, last_c = -1, end_c = -1, maxl = 0, stray = 0;
        logic [AW-1:0] exp_a;
        @(negedge clk);
        img_base = v.base; img_width_px = v.wpx; img_height = v.ht;
        img_pitch = v.pitch; img_wr = 1'b1; vseq_running = 1'b0;
        @(posedge clk); @(negedge clk);
        img_wr = 1'b0;
        chk(pf_busy && pf_prefetch, "R2 busy and prefetch after start",
            {pf_busy, pf_prefetch}, 3);
        for (int c = 0; c < 4000; c++) begin
            img_wr = (c == inject);
            if (c == inject) img_base = 24'h00F000;
            vseq_running = (c >= int'(v.vdelay));
            case (v.mode)
                2'd0: pop_en = 1'b1;
                2'd1: pop_en = (c % 3 == 0);
                default: pop_en = (c >= 60);
            endcase
            ack_en = (c % 4 != 1);
            #1;
            if (int'(fifo_level) > maxl) maxl = int'(fifo_level);
            if (mem_req && fifo_level >= LVLW'(DEPTH)) full_req++;
            if (fifo_push) begin
                exp_a = v.base + AW'(line) * v.pitch + AW'(word);
                if (mem_addr != exp_a) bad_addr++;
                if (fifo_wdata != (mem_addr[15:0] ^ 16'h5A3C)) bad_data++;
                pushes++; last_c = c; word++;
                if (word == wpl) begin word = 0; line++; end
            end
            if (c == int'(v.vdelay))
                chk(pf_prefetch == pf_busy, "R8 prefetch held before sequencer start",
                    pf_prefetch, pf_busy);
            if (c == int'(v.vdelay) + 1)
                chk(!pf_prefetch, "R8 prefetch cleared after sequencer start", pf_prefetch, 0);
            if (!pf_busy) begin end_c = c; break; end
            @(posedge clk); @(negedge clk);
        end
        img_wr = 1'b0; vseq_running = 1'b0;
        chk(pushes == total, "R3 words fetched", pushes, total);
        chk(bad_addr == 0, "R4 address sequence mismatches", bad_addr, 0);
        chk(bad_data == 0, "R6 pushed data mismatches", bad_data, 0);
        chk(full_req == 0, "R5 requests while FIFO full", full_req, 0);
        chk(end_c == last_c + 1, "R7 busy clear cycle", end_c, last_c + 1);
        chk(!pf_prefetch, "R8 prefetch clear at end", pf_prefetch, 0);
        chk(pf_error == exp_err, "R9 R11 error flag after fetch", pf_error, exp_err);
        if (v.mode == 2'd2) chk(maxl == DEPTH, "R5 FIFO filled to depth", maxl, DEPTH);
        pop_en = 1'b1; ack_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (mem_req || fifo_push) stray++;
        end
        chk(stray == 0, "R7 no requests after completion", stray, 0);
        chk(ovf == 0, "R5 FIFO overflows", ovf, 0);
        pop_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung, expected finished");
        summary();
    end

    initial begin
        int act;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({pf_busy, pf_prefetch, pf_error, mem_req, fifo_push} == 5'b0,
            "R1 outputs in reset", {pf_busy, pf_prefetch, pf_error, mem_req, fifo_push}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk({pf_busy, pf_prefetch, pf_error, mem_req} == 4'b0,
            "R1 outputs after reset", {pf_busy, pf_prefetch, pf_error, mem_req}, 0);

        for (int i = 0; i < 5; i++) run_vec(VECS[i], -1, 1'b0);

        // R9: start write while busy is refused
        run_vec('{14'd32, 12'd2, 24'h000008, 24'h000100, 2'd1, 8'd3}, 5, 1'b1);
        // R11: error survives a clean fetch
        run_vec(VECS[1], -1, 1'b1);

        // R11: only reset clears the error
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!pf_error, "R11 error cleared by reset", pf_error, 0);

        // R10: zero width, then zero height
        act = 0;
        img_width_px = '0; img_height = 12'd3; img_base = 24'h000400; img_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        img_width_px = 14'd40; img_height = '0;
        @(posedge clk); @(negedge clk);
        img_wr = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (pf_busy || mem_req || fifo_push) act++;
            @(posedge clk); @(negedge clk);
        end
        chk(act == 0, "R10 zero-size start activity cycles", act, 0);
        chk(pf_error, "R10 zero-size start sets error", pf_error, 1);

        summary();
    end
endmodule